// File: doc/BRIEF.md
# NRZI Line Coder with Zero-Bit Stuffing

This block turns a serial data stream into transition-coded line levels and recovers the data from such levels. A 1 leaves the line level where it was, and a 0 flips it. The transmit side takes one data bit per clock through a valid/ready handshake. When it has sent a run of six 1s, it inserts a 0 of its own so that the line keeps changing often enough for a receiver to stay in step. While that inserted bit goes out, it holds off its input for one cycle.

The receive side takes one sampled line level per bit clock, marked by a sample strobe. It turns the level back into a data bit by comparing it with the previous level. It removes the bit that follows six decoded 1s. If that bit is a 1, the stream has broken the stuffing rule, and the receiver flags it. Both sides start from an idle line level of 1. The two halves are independent, so a link is formed by connecting the transmit line outputs to the receive line inputs. Each clock cycle is one bit period, and the line is a plain logic bit.

Top module: `nrzi_stuff_codec`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_line_vld` is 0, `tx_ready` is 1, and `rx_out_vld` and `rx_stuff_err` are 0. The first bit on either side is coded relative to an idle level of 1: a first received level of 0 decodes as data 0, and a first received level of 1 decodes as data 1.
- R2: A data 1 accepted on the transmit handshake leaves `tx_line` unchanged in the next cycle, with `tx_line_vld` high.
- R3: A data 0 accepted on the transmit handshake inverts `tx_line` in the next cycle, with `tx_line_vld` high.
- R4: After six consecutively accepted 1s, the transmitter emits one inserted 0 in the next bit period. That bit inverts `tx_line`. `tx_ready` is low for exactly that one cycle, and the pending input bit is held. The ones-run count restarts from zero after the inserted bit and after every data 0.
- R5: The transmit line never shows seven consecutive bit periods without a level change.
- R6: The receiver decodes each sampled level as 1 when it equals the previous sampled level and as 0 otherwise. It presents the bit on `rx_out_data`, with `rx_out_vld` high for one cycle, in the cycle after the sample.
- R7: The receiver discards the sampled bit that follows six consecutive decoded 1s. For that bit, `rx_out_vld` stays low.
- R8: If the bit following six decoded 1s decodes as 1, `rx_stuff_err` goes high for exactly one cycle and no data is output. The ones-run count then restarts.
- R9: With `tx_valid` low and no inserted bit due, `tx_line_vld` stays low and `tx_line` holds its level. Idle cycles neither extend nor break the ones-run count.
- R10: When the transmit outputs drive the receive inputs, any input stream, including gapped streams and long runs of 1s, is recovered bit-exactly with no stuffing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bit period per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Transmit data bit is offered |
| tx_data | input | 1 | Transmit data bit |
| tx_ready | output | 1 | Transmitter takes the offered bit this cycle |
| tx_line | output | 1 | Coded transmit line level |
| tx_line_vld | output | 1 | `tx_line` carries a bit period this cycle |
| rx_sample | input | 1 | `rx_line` holds a sampled bit period this cycle |
| rx_line | input | 1 | Sampled receive line level |
| rx_out_vld | output | 1 | Decoded data bit is valid |
| rx_out_data | output | 1 | Decoded data bit |
| rx_stuff_err | output | 1 | One-cycle pulse on a stuffing violation |

## Verification
The assertions check the following on every cycle:
- the per-bit coding rules for accepted 1s and 0s;
- the one-cycle ready drop, with a line toggle on each inserted bit;
- the line holding still while idle;
- a counter-based bound on periods without a transition;
- receive outputs appearing only after a sample, and error pulses lasting one cycle and never coinciding with data.

Other behaviour can only be shown by the bench's scenarios:
- whether whole streams come back bit-exact;
- whether the number of inserted bits matches the run-length count of the input;
- whether the first bit after reset is referenced to the idle level;
- whether the receiver drops a legitimate inserted 0 but flags and drops an illegal 1.

// File: rtl/nrzi_pkg.sv
package nrzi_pkg;

    // Default number of consecutive ones that triggers an inserted zero.
    localparam int unsigned DEF_RUN_LEN = 6;

    // Width of a counter that must reach n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Classification of a sampled receive bit period.
    typedef enum logic [1:0] {
        BIT_DATA  = 2'd0,
        BIT_STUFF = 2'd1,
        BIT_VIOL  = 2'd2
    } rx_kind_e;

endpackage

// File: rtl/nrzi_tx.sv
module nrzi_tx #(
    parameter int unsigned RUN_LEN = nrzi_pkg::DEF_RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_data,
    output logic in_ready,
    output logic line_o,
    output logic line_vld_o
);
    localparam int unsigned     CW      = nrzi_pkg::cnt_width(RUN_LEN);
    localparam logic [CW-1:0]   RUN_MAX = CW'(RUN_LEN);

    typedef struct packed {
        logic          line;
        logic          vld;
        logic [CW-1:0] run;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   stuff_due;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        stuff_due = (st_q.run == RUN_MAX);
        if (stuff_due) begin
            // inserted zero: toggle the line, input waits
            st_d.line = ~st_q.line;
            st_d.vld  = 1'b1;
            st_d.run  = '0;
        end else if (in_valid) begin
            st_d.vld = 1'b1;
            if (in_data) begin
                st_d.run = st_q.run + 1'b1;
            end else begin
                st_d.line = ~st_q.line;
                st_d.run  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{line: 1'b1, vld: 1'b0, run: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready   = ~stuff_due;
    assign line_o     = st_q.line;
    assign line_vld_o = st_q.vld;

endmodule

// File: rtl/nrzi_rx.sv
module nrzi_rx #(
    parameter int unsigned RUN_LEN = nrzi_pkg::DEF_RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic line_i,
    output logic out_vld_o,
    output logic out_data_o,
    output logic err_o
);
    import nrzi_pkg::*;

    localparam int unsigned     CW      = cnt_width(RUN_LEN);
    localparam logic [CW-1:0]   RUN_MAX = CW'(RUN_LEN);

    typedef struct packed {
        logic          prev;
        logic          vld;
        logic          data;
        logic          err;
        logic [CW-1:0] run;
    } rx_st_t;

    rx_st_t   st_d, st_q;
    logic     dec_bit;
    rx_kind_e kind;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.err = 1'b0;
        dec_bit  = (line_i == st_q.prev);
        kind     = BIT_DATA;
        if (st_q.run == RUN_MAX) begin
            kind = dec_bit ? BIT_VIOL : BIT_STUFF;
        end
        if (sample_i) begin
            st_d.prev = line_i;
            unique case (kind)
                BIT_STUFF: st_d.run = '0;
                BIT_VIOL: begin
                    st_d.run = '0;
                    st_d.err = 1'b1;
                end
                default: begin
                    st_d.vld  = 1'b1;
                    st_d.data = dec_bit;
                    st_d.run  = dec_bit ? (st_q.run + 1'b1) : '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{prev: 1'b1, vld: 1'b0, data: 1'b0, err: 1'b0, run: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld_o  = st_q.vld;
    assign out_data_o = st_q.data;
    assign err_o      = st_q.err;

endmodule

// File: rtl/nrzi_stuff_codec.sv
module nrzi_stuff_codec #(
    parameter int unsigned RUN_LEN = nrzi_pkg::DEF_RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_valid,
    input  logic tx_data,
    output logic tx_ready,
    output logic tx_line,
    output logic tx_line_vld,
    input  logic rx_sample,
    input  logic rx_line,
    output logic rx_out_vld,
    output logic rx_out_data,
    output logic rx_stuff_err
);

    nrzi_tx #(.RUN_LEN(RUN_LEN)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (tx_valid),
        .in_data    (tx_data),
        .in_ready   (tx_ready),
        .line_o     (tx_line),
        .line_vld_o (tx_line_vld)
    );

    nrzi_rx #(.RUN_LEN(RUN_LEN)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (rx_sample),
        .line_i     (rx_line),
        .out_vld_o  (rx_out_vld),
        .out_data_o (rx_out_data),
        .err_o      (rx_stuff_err)
    );

endmodule

// File: rtl/nrzi_stuff_codec_chk.sv
module nrzi_stuff_codec_chk #(
    parameter int unsigned RUN_LEN = nrzi_pkg::DEF_RUN_LEN
) (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_data,
    input logic tx_ready,
    input logic tx_line,
    input logic tx_line_vld,
    input logic rx_sample,
    input logic rx_out_vld,
    input logic rx_stuff_err
);
    localparam int unsigned   FW       = nrzi_pkg::cnt_width(RUN_LEN + 1);
    localparam logic [FW-1:0] FLAT_CAP = FW'(RUN_LEN + 1);

    logic [FW-1:0] flat_q;
    logic          lvl_q;

    // counts bit periods since the last line transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flat_q <= '0;
            lvl_q  <= 1'b1;
        end else if (tx_line_vld) begin
            lvl_q <= tx_line;
            if (tx_line != lvl_q) begin
                flat_q <= '0;
            end else if (flat_q != FLAT_CAP) begin
                flat_q <= flat_q + 1'b1;
            end
        end
    end

    a_r2_one_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_data) |=> (tx_line_vld && tx_line == $past(tx_line)));

    a_r3_zero_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !tx_data) |=> (tx_line_vld && tx_line != $past(tx_line)));

    a_r4_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ready |=> tx_ready);

    a_r4_stuff_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ready |=> (tx_line_vld && tx_line != $past(tx_line)));

    a_r5_transition_window: assert property (@(posedge clk) disable iff (!rst_n)
        flat_q <= FW'(RUN_LEN));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_line_vld |-> $stable(tx_line));

    a_r6_out_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_vld |-> $past(rx_sample));

    a_r8_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_stuff_err && rx_out_vld));

    a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stuff_err |=> !rx_stuff_err);

endmodule

bind nrzi_stuff_codec nrzi_stuff_codec_chk #(.RUN_LEN(RUN_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_ready     (tx_ready),
    .tx_line      (tx_line),
    .tx_line_vld  (tx_line_vld),
    .rx_sample    (rx_sample),
    .rx_out_vld   (rx_out_vld),
    .rx_stuff_err (rx_stuff_err)
);

// File: tb/nrzi_stuff_codec_tb.sv
module nrzi_stuff_codec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RUN        = 6;
    localparam int MAXB       = 512;
    localparam int WDOG       = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_valid = 1'b0, tx_data = 1'b0;
    logic tx_ready, tx_line, tx_line_vld;
    logic rx_sample, rx_line, rx_out_vld, rx_out_data, rx_stuff_err;
    logic direct = 1'b0, d_vld = 1'b0, d_line = 1'b1;

    assign rx_sample = direct ? d_vld  : tx_line_vld;
    assign rx_line   = direct ? d_line : tx_line;

    nrzi_stuff_codec #(.RUN_LEN(RUN)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .tx_line(tx_line), .tx_line_vld(tx_line_vld),
        .rx_sample(rx_sample), .rx_line(rx_line),
        .rx_out_vld(rx_out_vld), .rx_out_data(rx_out_data),
        .rx_stuff_err(rx_stuff_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    bit sent [MAXB];
    bit got  [MAXB];
    int ngot, nline, flat, max_flat, nerr, stalls;
    logic last_lvl;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
            summary();
        end
    end

    // loopback monitor
    always @(negedge clk) begin
        if (rst_n && !direct) begin
            if (rx_out_vld) begin
                if (ngot < MAXB) got[ngot] = rx_out_data;
                ngot++;
            end
            if (rx_stuff_err) nerr++;
            if (tx_line_vld) begin
                nline++;
                if (tx_line == last_lvl) flat++; else flat = 0;
                if (flat > max_flat) max_flat = flat;
                last_lvl = tx_line;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        tx_valid = 1'b0;
        d_vld    = 1'b0;
        d_line   = 1'b1;
        rst_n    = 1'b0;
        ngot = 0; nline = 0; flat = 0; max_flat = 0; nerr = 0; stalls = 0;
        last_lvl = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input bit b);
        tx_valid = 1'b1;
        tx_data  = b;
        while (!tx_ready) begin
            stalls++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic drive_rx(input bit lvl);
        d_vld  = 1'b1;
        d_line = lvl;
        @(negedge clk);
        d_vld  = 1'b0;
    endtask

    // inserted-bit count from the run-length rule; trail set when the last one ends on a stuff
    function automatic int exp_stuffs(input int n, output bit trail);
        int run = 0, s = 0;
        trail = 1'b0;
        for (int i = 0; i < n; i++) begin
            trail = 1'b0;
            if (sent[i]) run++; else run = 0;
            if (run == RUN) begin s++; run = 0; trail = 1'b1; end
        end
        return s;
    endfunction

    task automatic run_stream(input int n, input bit gaps);
        int  s, mism;
        bit  trail;
        do_reset();
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                tx_valid = 1'b0;
                repeat (1 + $urandom % 3) @(negedge clk);
            end
            send_bit(sent[i]);
        end
        tx_valid = 1'b0;
        repeat (5) @(negedge clk);
        s = exp_stuffs(n, trail);
        mism = 0;
        for (int i = 0; i < n && i < ngot; i++) if (got[i] != sent[i]) mism++;
        chk(ngot == n, "R10", "recovered bit count", ngot, n);
        chk(mism == 0, "R10", "recovered bit mismatches", mism, 0);
        chk(nerr == 0, "R10", "stuff errors in loopback", nerr, 0);
        chk(nline == n + s, gaps ? "R9" : "R4", "line bit periods", nline, n + s);
        chk(max_flat <= RUN, "R5", "periods without transition", max_flat, RUN);
        if (!gaps)
            chk(stalls == s - int'(trail), "R4", "ready-low cycles", stalls, s - int'(trail));
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(tx_line == 1'b1, "R1", "idle line", tx_line, 1);
        chk(tx_line_vld == 1'b0, "R1", "line valid", tx_line_vld, 0);
        chk(tx_ready == 1'b1, "R1", "ready", tx_ready, 1);
        chk(rx_out_vld == 1'b0 && rx_stuff_err == 1'b0, "R1", "rx outputs", rx_out_vld, 0);

        // R9: idle keeps the line still
        repeat (4) @(negedge clk);
        chk(tx_line_vld == 1'b0 && tx_line == 1'b1, "R9", "idle line", tx_line, 1);

        // R2 / R3 first bits referenced to idle 1
        send_bit(1'b1);
        chk(tx_line_vld && tx_line == 1'b1, "R2", "one keeps level", tx_line, 1);
        send_bit(1'b0);
        chk(tx_line_vld && tx_line == 1'b0, "R3", "zero toggles", tx_line, 0);
        send_bit(1'b1);
        chk(tx_line == 1'b0, "R2", "one keeps low level", tx_line, 0);
        tx_valid = 1'b0;

        // R4: six ones then stall with toggle
        do_reset();
        for (int i = 0; i < RUN; i++) send_bit(1'b1);
        tx_data = 1'b1;
        chk(tx_ready == 1'b0, "R4", "ready low after six ones", tx_ready, 0);
        @(negedge clk);
        chk(tx_line_vld && tx_line == 1'b0, "R4", "stuff bit toggles", tx_line, 0);
        chk(tx_ready == 1'b1, "R4", "ready back after one cycle", tx_ready, 1);
        tx_valid = 1'b0;

        // R1 / R6: receive first bit against idle level
        direct = 1'b1;
        do_reset();
        drive_rx(1'b0);
        chk(rx_out_vld && rx_out_data == 1'b0, "R1", "rx first level 0 decodes 0", rx_out_data, 0);
        drive_rx(1'b0);
        chk(rx_out_vld && rx_out_data == 1'b1, "R6", "rx equal level decodes 1", rx_out_data, 1);
        drive_rx(1'b1);
        chk(rx_out_vld && rx_out_data == 1'b0, "R6", "rx change decodes 0", rx_out_data, 0);
        @(negedge clk);
        chk(rx_out_vld == 1'b0, "R6", "no output without sample", rx_out_vld, 0);

        do_reset();
        drive_rx(1'b1);
        chk(rx_out_vld && rx_out_data == 1'b1, "R1", "rx first level 1 decodes 1", rx_out_data, 1);

        // R8: violation after six ones
        do_reset();
        for (int i = 0; i < RUN; i++) begin
            drive_rx(1'b1);
            chk(rx_out_vld && rx_out_data == 1'b1, "R6", "rx ones run", rx_out_data, 1);
        end
        drive_rx(1'b1);
        chk(rx_stuff_err == 1'b1, "R8", "error pulse", rx_stuff_err, 1);
        chk(rx_out_vld == 1'b0, "R8", "violating bit dropped", rx_out_vld, 0);
        drive_rx(1'b0);
        chk(rx_stuff_err == 1'b0, "R8", "error one cycle", rx_stuff_err, 0);
        chk(rx_out_vld && rx_out_data == 1'b0, "R8", "decode resumes", rx_out_data, 0);

        // R7: legitimate stuffed zero is removed
        do_reset();
        for (int i = 0; i < RUN; i++) drive_rx(1'b1);
        drive_rx(1'b0);
        chk(rx_out_vld == 1'b0 && rx_stuff_err == 1'b0, "R7", "stuff bit dropped", rx_out_vld, 0);
        drive_rx(1'b0);
        chk(rx_out_vld && rx_out_data == 1'b1, "R7", "next bit after stuff", rx_out_data, 1);
        direct = 1'b0;

        // R10: all 10-bit patterns
        for (int v = 0; v < 1024; v++) begin
            for (int i = 0; i < 10; i++) sent[i] = v[i];
            run_stream(10, 1'b0);
        end

        // R4 / R5: long runs of ones around a zero
        for (int k = 0; k <= 20; k++) begin
            for (int i = 0; i < k; i++) sent[i] = 1'b1;
            sent[k] = 1'b0;
            for (int i = 0; i < k; i++) sent[k + 1 + i] = 1'b1;
            run_stream(2 * k + 1, 1'b0);
        end

        // R9 / R10: random ones-heavy streams with idle gaps
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 300; i++) sent[i] = ($urandom % 4) != 0;
            run_stream(300, 1'b1);
        end

        summary();
    end

endmodule